// File: doc/BRIEF.md
# Cache Line Burst Sequencer

This block produces the bus transfers that fill one 32-byte cache line, which holds four 64-bit quadwords. A fill request arrives with the quadword address the core needs first. The sequencer then drives the address, the transfer kind and the cacheable flag for each transfer. The bus answers every transfer with one bus-ready pulse. Line storage and the system chipset are outside the block.

The sequencer has two fill orders. A configuration bit selects between them, and the bit is captured when a request is accepted. With the bit clear, the sequencer uses the critical-read-then-burst mode, which is the setting after reset. In this mode a request for an odd quadword starts with a non-cacheable single read of that quadword, so the critical data arrives early. The cache-enable response taken on that read decides whether a four-beat burst follows. A request for an even quadword goes straight to the burst. With the bit set, the sequencer uses linear mode: the burst begins at the requested quadword and wraps around the line.

Requests use a valid/ready handshake. The sequencer takes a request in the cycle where both `req_valid` and `req_ready` are high. `req_ready` is high only while no fill is in progress, so a requester holds `req_valid` and its address until that cycle. The bus side has no back-pressure beyond `bus_rdy`.

Top module: `line_fill_sequencer`

## Requirements
- R1: After reset, `req_ready` is 1, `cyc_active` is 0 and `done` is 0.
- R2: A request is taken only in a cycle where both `req_valid` and `req_ready` are 1. `req_ready` is 0 from the cycle after acceptance until the fill ends. A `req_valid` during that time has no effect on the transfers.
- R3: In critical-read mode (`linear_mode` = 0), a request whose quadword index (`req_addr[4:3]`) is 1 or 3 first issues one transfer with `cyc_burst` = 0 and `cyc_cacheable` = 0, at the requested quadword address.
- R4: The sequencer samples `cache_en` on the `bus_rdy` of that single read. If `cache_en` is 1, a burst follows. If it is 0, the fill ends after the single read and no burst is issued.
- R5: A burst that follows a single read starts at index 0 when the request was index 1, giving indices 0,1,2,3. It starts at index 2 when the request was index 3, giving indices 2,3,0,1.
- R6: In critical-read mode, a request at index 0 or 2 starts the burst at once with no single read. The orders are 0,1,2,3 and 2,3,0,1.
- R7: In linear mode (`linear_mode` = 1), every request starts a burst at the requested index with no single read. The index then increases by one modulo 4 on each beat.
- R8: A transfer completes only in a cycle where `bus_rdy` is 1. While `bus_rdy` is 0, `cyc_addr`, `cyc_burst` and `cyc_cacheable` hold their values.
- R9: Every burst transfer has `cyc_burst` = 1 and `cyc_cacheable` = 1. `cyc_addr` keeps the line bits of the request, with bits [2:0] at zero. `done` is high for exactly one cycle, the cycle after the final transfer completes.
- R10: The mode is taken from `linear_mode` at acceptance. A change of `linear_mode` during a fill does not alter that fill's transfers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Fill request present |
| req_ready | output | 1 | Sequencer is able to accept a request |
| req_addr | input | ADDR_W | Address of the critical quadword |
| linear_mode | input | 1 | Configuration bit: 1 selects linear order, 0 selects critical-read mode |
| cache_en | input | 1 | Cache-enable response from the system |
| bus_rdy | input | 1 | Current transfer completes this cycle |
| cyc_active | output | 1 | A transfer is being driven |
| cyc_addr | output | ADDR_W | Quadword address of the current transfer |
| cyc_burst | output | 1 | 1 for a burst beat, 0 for a single read |
| cyc_cacheable | output | 1 | Current transfer is cacheable |
| done | output | 1 | One-cycle pulse after the final transfer of a fill |

## Verification
The assertions check on every cycle the rules that do not depend on the scenario. These are: transfers hold their values while the bus stalls, acceptance happens only when idle, a single read is non-cacheable and sits at an odd quadword, burst indices step by one, `done` lasts one cycle, and the outcome of the `cache_en` sample. Only the bench scenarios can show the full address order for each mode and starting quadword, the dropped burst when the cache-enable response is refused, and whether a mode toggle or a stray request during a fill has any effect. The bench compares every completed transfer against the expected order, with random bus stalls.

// File: rtl/lfs_pkg.sv
package lfs_pkg;
  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_SINGLE = 2'd1,
    ST_BURST  = 2'd2
  } lfs_state_e;
endpackage

// File: rtl/lfs_ctrl.sv
module lfs_ctrl
  import lfs_pkg::*;
#(
  parameter int LINE_QWORDS = 4,
  localparam int IDX_W = $clog2(LINE_QWORDS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic [IDX_W-1:0] req_idx,
  input  logic             linear_mode,
  input  logic             cache_en,
  input  logic             bus_rdy,
  output logic             accept,
  output lfs_state_e       state,
  output logic [IDX_W-1:0] beat,
  output logic [IDX_W-1:0] start_idx,
  output logic [IDX_W-1:0] crit_idx,
  output logic             done
);
  localparam logic [IDX_W-1:0] LAST_BEAT = IDX_W'(LINE_QWORDS - 1);

  // odd critical quadword in critical-read mode needs a leading single read
  logic needs_single;
  assign accept       = (state == ST_IDLE) && req_valid;
  assign needs_single = !linear_mode && req_idx[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      beat      <= '0;
      start_idx <= '0;
      crit_idx  <= '0;
      done      <= 1'b0;
    end else begin
      done <= 1'b0;
      unique case (state)
        ST_IDLE: if (accept) begin
          crit_idx  <= req_idx;
          beat      <= '0;
          start_idx <= linear_mode ? req_idx : {req_idx[IDX_W-1:1], 1'b0};
          state     <= needs_single ? ST_SINGLE : ST_BURST;
        end
        ST_SINGLE: if (bus_rdy) begin
          if (cache_en) begin
            state <= ST_BURST;
            beat  <= '0;
          end else begin
            state <= ST_IDLE;
            done  <= 1'b1;
          end
        end
        ST_BURST: if (bus_rdy) begin
          if (beat == LAST_BEAT) begin
            state <= ST_IDLE;
            done  <= 1'b1;
          end else begin
            beat <= beat + 1'b1;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R4: granted cache-enable on the single read moves to the first burst beat
  assert_single_to_burst_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_SINGLE && bus_rdy && cache_en) |=> (state == ST_BURST && beat == '0));

  // R4: refused cache-enable ends the fill with no burst
  assert_refused_ends_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_SINGLE && bus_rdy && !cache_en) |=> (state == ST_IDLE && done));

  // R9: done is a single-cycle pulse
  assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R8: no progress without bus-ready
  assert_beat_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (state != ST_IDLE && !bus_rdy) |=> ($stable(state) && $stable(beat)));
endmodule

// File: rtl/lfs_addr_gen.sv
module lfs_addr_gen
  import lfs_pkg::*;
#(
  parameter int ADDR_W      = 32,
  parameter int LINE_QWORDS = 4,
  parameter int QW_BYTES    = 8,
  localparam int IDX_W  = $clog2(LINE_QWORDS),
  localparam int OFS_W  = $clog2(QW_BYTES),
  localparam int LINE_W = ADDR_W - IDX_W - OFS_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              capture,
  input  logic [ADDR_W-1:0] req_addr,
  input  lfs_state_e        state,
  input  logic [IDX_W-1:0]  beat,
  input  logic [IDX_W-1:0]  start_idx,
  input  logic [IDX_W-1:0]  crit_idx,
  output logic [ADDR_W-1:0] cyc_addr
);
  logic [LINE_W-1:0] line_q;
  logic [IDX_W-1:0]  cur_idx;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       line_q <= '0;
    else if (capture) line_q <= req_addr[ADDR_W-1 -: LINE_W];
  end

  // burst index wraps naturally in IDX_W bits
  assign cur_idx  = (state == ST_SINGLE) ? crit_idx : IDX_W'(start_idx + beat);
  assign cyc_addr = {line_q, cur_idx, {OFS_W{1'b0}}};

  // R3: a single read always targets an odd quadword
  assert_single_odd_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_SINGLE) |-> cyc_addr[OFS_W]);

  // R7: consecutive burst beats step the index by one modulo the line
  assert_burst_step_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_BURST && $past(state) == ST_BURST && beat != $past(beat))
      |-> (cur_idx == IDX_W'($past(cur_idx) + 1'b1)));
endmodule

// File: rtl/line_fill_sequencer.sv
module line_fill_sequencer
  import lfs_pkg::*;
#(
  parameter int ADDR_W      = 32,
  parameter int LINE_QWORDS = 4,
  parameter int QW_BYTES    = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic              linear_mode,
  input  logic              cache_en,
  input  logic              bus_rdy,
  output logic              cyc_active,
  output logic [ADDR_W-1:0] cyc_addr,
  output logic              cyc_burst,
  output logic              cyc_cacheable,
  output logic              done
);
  localparam int IDX_W = $clog2(LINE_QWORDS);
  localparam int OFS_W = $clog2(QW_BYTES);

  lfs_state_e       state;
  logic             accept;
  logic [IDX_W-1:0] beat, start_idx, crit_idx;

  lfs_ctrl #(.LINE_QWORDS(LINE_QWORDS)) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .req_idx    (req_addr[OFS_W +: IDX_W]),
    .linear_mode(linear_mode),
    .cache_en   (cache_en),
    .bus_rdy    (bus_rdy),
    .accept     (accept),
    .state      (state),
    .beat       (beat),
    .start_idx  (start_idx),
    .crit_idx   (crit_idx),
    .done       (done)
  );

  lfs_addr_gen #(
    .ADDR_W     (ADDR_W),
    .LINE_QWORDS(LINE_QWORDS),
    .QW_BYTES   (QW_BYTES)
  ) u_addr (
    .clk      (clk),
    .rst_n    (rst_n),
    .capture  (accept),
    .req_addr (req_addr),
    .state    (state),
    .beat     (beat),
    .start_idx(start_idx),
    .crit_idx (crit_idx),
    .cyc_addr (cyc_addr)
  );

  assign req_ready     = (state == ST_IDLE);
  assign cyc_active    = (state != ST_IDLE);
  assign cyc_burst     = (state == ST_BURST);
  assign cyc_cacheable = (state == ST_BURST);

  // R8: a stalled transfer holds its address and kind
  assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc_active && !bus_rdy) |=> (cyc_active && $stable(cyc_addr) && $stable(cyc_burst)
                                  && $stable(cyc_cacheable)));

  // R2: no transfer is driven while a request can be accepted
  assert_ready_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> !cyc_active);

  // R3: a non-burst transfer is never cacheable
  assert_single_noncache_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc_active && !cyc_burst) |-> !cyc_cacheable);

  // R9: done only follows a completed transfer
  assert_done_after_rdy_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> ($past(bus_rdy) && $past(cyc_active)));
endmodule

// File: tb/test_line_fill_sequencer.sv
module test_line_fill_sequencer;
  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W     = 32;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              req_valid = 1'b0;
  logic              req_ready;
  logic [ADDR_W-1:0] req_addr = '0;
  logic              linear_mode = 1'b0;
  logic              cache_en = 1'b0;
  logic              bus_rdy = 1'b0;
  logic              cyc_active;
  logic [ADDR_W-1:0] cyc_addr;
  logic              cyc_burst;
  logic              cyc_cacheable;
  logic              done;

  int checks = 0;
  int fails  = 0;
  bit finished = 0;

  // expected transfers: {addr, burst, cacheable} plus requirement tag
  logic [ADDR_W+1:0] exp_q[$];
  string             tag_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  line_fill_sequencer #(.ADDR_W(ADDR_W)) i_line_fill_sequencer (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .linear_mode(linear_mode), .cache_en(cache_en),
    .bus_rdy(bus_rdy), .cyc_active(cyc_active), .cyc_addr(cyc_addr),
    .cyc_burst(cyc_burst), .cyc_cacheable(cyc_cacheable), .done(done)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // bus responder: random stalls while a transfer is driven
  initial forever begin
    @(posedge clk);
    #1;
    bus_rdy = cyc_active && ($urandom_range(0, 3) != 0);
  end

  // monitor: pops one expected item for every completed transfer
  initial forever begin
    @(negedge clk);
    if (rst_n && cyc_active && bus_rdy) begin
      if (exp_q.size() == 0) begin
        check(1'b0, "R4", "unexpected transfer", {30'd0, cyc_burst, cyc_cacheable, cyc_addr}, 0);
      end else begin
        logic [ADDR_W+1:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        check({cyc_burst, cyc_cacheable, cyc_addr} == e, t, "transfer {burst,cache,addr}",
              {30'd0, cyc_burst, cyc_cacheable, cyc_addr}, {30'd0, e});
      end
    end
  end

  // driver: computes the expected transfers, then issues the request
  task automatic do_fill(input logic [ADDR_W-1:0] addr, input bit lin, input bit ken);
    logic [ADDR_W-1:0] base;
    int idx, s;
    string t;
    base = {addr[ADDR_W-1:5], 5'b0};
    idx  = int'(addr[4:3]);
    if (!lin && (idx % 2 == 1)) begin
      exp_q.push_back({1'b0, 1'b0, base | ADDR_W'(idx * 8)});
      tag_q.push_back("R3");
      if (ken) begin
        s = (idx == 1) ? 0 : 2;  // R5 order after the single read
        for (int k = 0; k < 4; k++) begin
          exp_q.push_back({1'b1, 1'b1, base | ADDR_W'(((s + k) % 4) * 8)});
          tag_q.push_back("R5");
        end
      end
    end else begin
      t = lin ? "R7" : "R6";
      for (int k = 0; k < 4; k++) begin
        exp_q.push_back({1'b1, 1'b1, base | ADDR_W'(((idx + k) % 4) * 8)});
        tag_q.push_back(t);
      end
    end

    @(posedge clk); #1;
    req_valid   = 1'b1;
    req_addr    = addr;
    linear_mode = lin;
    cache_en    = ken;
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    @(posedge clk); #1;
    // stray request and mode flip during the fill (R2, R10)
    req_addr    = addr ^ 32'h0000_0018;
    linear_mode = !lin;
    @(negedge clk);
    check(req_ready == 1'b0, "R2", "req_ready while busy", req_ready, 0);
    @(posedge clk); #1;
    req_valid = 1'b0;

    @(negedge clk);
    while (!done) @(negedge clk);
    check(exp_q.size() == 0, "R9", "transfers left at done", exp_q.size(), 0);
    check(cyc_active == 1'b0, ken || lin || (idx % 2 == 0) ? "R9" : "R4",
          "idle at done", cyc_active, 0);
    @(negedge clk);
    check(done == 1'b0, "R9", "done width", done, 0);
    exp_q.delete();
    tag_q.delete();
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  endtask

  initial begin
    repeat (1000000 / CLK_PERIOD) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    check(req_ready == 1'b1, "R1", "req_ready after reset", req_ready, 1);
    check(cyc_active == 1'b0, "R1", "cyc_active after reset", cyc_active, 0);
    check(done == 1'b0, "R1", "done after reset", done, 0);

    // critical-read mode, all four quadwords, cache-enable granted
    do_fill(32'h1000_0008, 1'b0, 1'b1);
    do_fill(32'h1000_0018, 1'b0, 1'b1);
    do_fill(32'h2000_0040, 1'b0, 1'b1);
    do_fill(32'h2000_0070, 1'b0, 1'b1);
    // refused cache-enable on the single read: no burst
    do_fill(32'h3000_00A8, 1'b0, 1'b0);
    do_fill(32'h3000_00B8, 1'b0, 1'b0);
    // even quadwords ignore cache-enable for the start decision
    do_fill(32'h3000_00D0, 1'b0, 1'b0);
    // linear mode, every starting quadword
    do_fill(32'h4000_0100, 1'b1, 1'b0);
    do_fill(32'h4000_0108, 1'b1, 1'b1);
    do_fill(32'h4000_0110, 1'b1, 1'b0);
    do_fill(32'hFFFF_FFF8, 1'b1, 1'b1);
    // back to critical-read mode after linear fills
    do_fill(32'h5000_0018, 1'b0, 1'b1);

    finish_run();
  end
endmodule